// File: doc/BRIEF.md
# Programmable Quadrature Track Interpolator

This block converts the state of a bank of phase comparators into two square-wave tracks, A and B, that stand a quarter of an output cycle apart, at one of four interpolation factors. The comparator bank is seen as a vector of `NBITS` (160 by default) levels. As the sensed phase advances, exactly one comparator switches per step, in ascending index order. Each step toggles bit `j = step mod NBITS`, so every comparator changes once per input period. Each track is a pure parity (XOR reduction) over a subset of those bits. The factor decides which subset is used. No counter or sequencer is involved.

A separate reference comparator level is passed through the same two-stage register path to a reference output, so it stays aligned with the tracks. The factor is set through a 2-bit code that the block captures only on a load strobe. The tracks feed an external up/down position counter. The pins are plain levels with no handshake, because a comparator state is a level and not a transfer.

Top module: `quad_interp`

## Requirements
- R1: While `rst_n` is low, `a_out`, `b_out` and `ref_out` are 0. Reset selects factor code 0 (factor 1).
- R2: The factor code `fsel` maps code 0 to factor 1, code 1 to factor 4, code 2 to factor 20 and code 3 to factor 40. For factor K the selected comparators are the bits at indices i*(40/K), for i = 0 .. 4K-1.
- R3: `a_out` is the XOR of the selected bits with even i. `b_out` is the XOR of the selected bits with odd i. An all-zero comparator vector gives A = B = 0.
- R4: When the vector steps upward one bit per step, over 160 steps `a_out` rises exactly K times and `b_out` rises exactly K times. B's first rise comes 40/K steps after A's first rise, so B lags A.
- R5: When the vector steps downward one bit per step, B's first rise comes 40/K steps before A's first rise, so B leads A.
- R6: A comparator vector that changes by at most one bit between clock edges never toggles both tracks in the same cycle.
- R7: `ref_out` equals `ref_cmp` as it was two clock edges earlier.
- R8: `a_out` and `b_out` reflect `cmp_in` as sampled two clock edges earlier. They use the factor captured on or before the previous edge. A factor loaded at edge n first governs the outputs at edge n+1.
- R9: While `load_en` is low, changes of `fsel` have no effect on either track.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_in | input | NBITS | Comparator bank levels, one bit per comparator |
| ref_cmp | input | 1 | Reference-channel comparator level |
| fsel | input | 2 | Interpolation factor code (0:1, 1:4, 2:20, 3:40) |
| load_en | input | 1 | Captures `fsel` at the rising edge while high |
| a_out | output | 1 | Quadrature track A |
| b_out | output | 1 | Quadrature track B |
| ref_out | output | 1 | Registered reference position level |

## Verification
Full ascending sweeps at each of the four factors count track rises and measure the A-to-B gap. These sweeps separate a wrong stride or a swapped even/odd assignment from a correct one. Descending sweeps show that the phase relation flips with direction. A sweep run after `fsel` is changed without a load shows whether the code leaks past the strobe. The default factor after reset is checked the same way. A pseudo-random reference level, combined with a cycle-by-cycle parity model, catches latency errors and misaligned registers on every edge.

// File: rtl/quad_interp_pkg.sv
package quad_interp_pkg;
  localparam int QI_MAX_FACT = 40;
  localparam int QI_PHASES   = 4;

  typedef enum logic [1:0] {
    FX1  = 2'd0,
    FX4  = 2'd1,
    FX20 = 2'd2,
    FX40 = 2'd3
  } fact_e;

  function automatic int fact_value(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 20;
      default: return 40;
    endcase
  endfunction

  function automatic int fact_stride(input logic [1:0] code);
    return QI_MAX_FACT / fact_value(code);
  endfunction
endpackage

// File: rtl/qi_sample.sv
module qi_sample
  import quad_interp_pkg::*;
#(
  parameter int NBITS = 160
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] cmp_in,
  input  logic             ref_cmp,
  input  logic [1:0]       fsel,
  input  logic             load_en,
  output logic [NBITS-1:0] cmp_q,
  output logic             ref_q,
  output fact_e            fact_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      ref_q  <= 1'b0;
      fact_q <= FX1;
    end else begin
      cmp_q <= cmp_in;
      ref_q <= ref_cmp;
      if (load_en) fact_q <= fact_e'(fsel);
    end
  end
endmodule

// File: rtl/qi_track_xor.sv
module qi_track_xor
  import quad_interp_pkg::*;
#(
  parameter int NBITS = 160
) (
  input  logic [NBITS-1:0] cmp_q,
  input  fact_e            fact_q,
  output logic             a_nxt,
  output logic             b_nxt
);
  localparam int NCODES = 4;

  function automatic logic [NBITS-1:0] pick(input int step, input int odd);
    logic [NBITS-1:0] m;
    m = '0;
    for (int i = 0; i < NBITS; i++)
      if ((i % step) == 0 && ((i / step) % 2) == odd) m[i] = 1'b1;
    return m;
  endfunction

  logic [NCODES-1:0] par_a, par_b;

  for (genvar c = 0; c < NCODES; c++) begin : g_code
    localparam int STEP = fact_stride(c[1:0]);
    localparam logic [NBITS-1:0] MASK_A = pick(STEP, 0);
    localparam logic [NBITS-1:0] MASK_B = pick(STEP, 1);
    assign par_a[c] = ^(cmp_q & MASK_A);
    assign par_b[c] = ^(cmp_q & MASK_B);
  end

  always_comb begin
    a_nxt = par_a[fact_q];
    b_nxt = par_b[fact_q];
  end
endmodule

// File: rtl/qi_out_reg.sv
module qi_out_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic a_nxt,
  input  logic b_nxt,
  input  logic ref_q,
  output logic a_out,
  output logic b_out,
  output logic ref_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_out   <= 1'b0;
      b_out   <= 1'b0;
      ref_out <= 1'b0;
    end else begin
      a_out   <= a_nxt;
      b_out   <= b_nxt;
      ref_out <= ref_q;
    end
  end
endmodule

// File: rtl/quad_interp.sv
module quad_interp
  import quad_interp_pkg::*;
#(
  parameter int NBITS = QI_MAX_FACT * QI_PHASES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] cmp_in,
  input  logic             ref_cmp,
  input  logic [1:0]       fsel,
  input  logic             load_en,
  output logic             a_out,
  output logic             b_out,
  output logic             ref_out
);
  logic [NBITS-1:0] cmp_q;
  logic             ref_q;
  fact_e            fact_q;
  logic             a_nxt, b_nxt;

  qi_sample #(.NBITS(NBITS)) sample_i (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .ref_cmp(ref_cmp),
    .fsel(fsel), .load_en(load_en),
    .cmp_q(cmp_q), .ref_q(ref_q), .fact_q(fact_q)
  );

  qi_track_xor #(.NBITS(NBITS)) xor_i (
    .cmp_q(cmp_q), .fact_q(fact_q), .a_nxt(a_nxt), .b_nxt(b_nxt)
  );

  qi_out_reg out_i (
    .clk(clk), .rst_n(rst_n), .a_nxt(a_nxt), .b_nxt(b_nxt), .ref_q(ref_q),
    .a_out(a_out), .b_out(b_out), .ref_out(ref_out)
  );
endmodule

// File: rtl/quad_interp_chk.sv
module quad_interp_chk #(
  parameter int NBITS = 160
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBITS-1:0] cmp_in,
  input logic             ref_cmp,
  input logic             load_en,
  input logic             a_out,
  input logic             b_out,
  input logic             ref_out
);
  logic [2:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!a_out && !b_out && !ref_out));

  p_zero_vector_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd3 && $past(cmp_in, 2) == '0) |-> (!a_out && !b_out));

  p_no_twin_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd4 && !$past(load_en) &&
     $countones($past(cmp_in, 2) ^ $past(cmp_in, 3)) <= 1)
    |-> !((a_out != $past(a_out)) && (b_out != $past(b_out))));

  p_ref_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd3) |-> (ref_out == $past(ref_cmp, 2)));

  p_hold_when_still_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd4 && !$past(load_en) && $past(cmp_in, 2) == $past(cmp_in, 3))
    |-> ($stable(a_out) && $stable(b_out)));
endmodule

bind quad_interp quad_interp_chk #(.NBITS(NBITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .ref_cmp(ref_cmp),
  .load_en(load_en), .a_out(a_out), .b_out(b_out), .ref_out(ref_out)
);

// File: tb/quad_interp_tb_top.sv
`timescale 1ns/1ps
module quad_interp_tb_top;
  localparam int NB = 160;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] cmp_in = '0;
  logic          ref_cmp = 1'b0;
  logic [1:0]    fsel = 2'd0;
  logic          load_en = 1'b0;
  logic          a_out, b_out, ref_out;

  int checks = 0;
  int errors = 0;

  quad_interp #(.NBITS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .ref_cmp(ref_cmp),
    .fsel(fsel), .load_en(load_en),
    .a_out(a_out), .b_out(b_out), .ref_out(ref_out)
  );

  always #2.5 clk = ~clk;

  function automatic int kval(input logic [1:0] c);
    case (c) 2'd0: return 1; 2'd1: return 4; 2'd2: return 20; default: return 40; endcase
  endfunction

  function automatic bit ref_track(input logic [NB-1:0] v, input logic [1:0] c, input int odd);
    int k, st; bit p;
    k = kval(c); st = 40 / k; p = 1'b0;
    for (int i = 0; i < 4 * k; i++) if ((i % 2) == odd) p ^= v[i * st];
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model state
  logic [NB-1:0] m_cmp = '0;
  logic [1:0]    m_fact = 2'd0;
  bit            m_ref = 1'b0;
  bit            pa = 0, pb = 0;
  bit            mon_on = 0;
  int            mcyc = 0, a_rise = 0, b_rise = 0, a_first = -1, b_first = -1, twins = 0;
  int            model_bad = 0;

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      m_cmp = '0; m_fact = 2'd0; m_ref = 1'b0;
    end else begin
      // R8: tracks follow the vector two edges back; R7: reference likewise
      if (a_out !== ref_track(m_cmp, m_fact, 0) || b_out !== ref_track(m_cmp, m_fact, 1)
          || ref_out !== m_ref) begin
        model_bad++;
        if (model_bad < 5)
          $display("FAIL R8 actual a/b/ref=%0d%0d%0d expected=%0d%0d%0d at %0t", a_out, b_out,
                   ref_out, ref_track(m_cmp, m_fact, 0), ref_track(m_cmp, m_fact, 1), m_ref, $time);
      end
      m_cmp = cmp_in; m_ref = ref_cmp;
      if (load_en) m_fact = fsel;
    end
    if (mon_on) begin
      if (a_out && !pa) begin a_rise++; if (a_first < 0) a_first = mcyc; end
      if (b_out && !pb) begin b_rise++; if (b_first < 0) b_first = mcyc; end
      if (a_out != pa && b_out != pb) twins++;
      mcyc++;
    end
    pa = a_out; pb = b_out;
  end

  logic [15:0] lfsr = 16'hACE1;

  task automatic step_bit(input int j);
    @(negedge clk);
    cmp_in[j] = ~cmp_in[j];
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ref_cmp = lfsr[0];
  endtask

  task automatic load_factor(input logic [1:0] c);
    @(negedge clk); fsel = c; load_en = 1'b1;
    @(negedge clk); load_en = 1'b0; fsel = ~c;
    repeat (2) @(negedge clk);
  endtask

  task automatic sweep(input logic [1:0] c, input bit up, input string req);
    int k, st;
    k = kval(c); st = 40 / k;
    a_rise = 0; b_rise = 0; a_first = -1; b_first = -1; twins = 0; mcyc = 0;
    @(negedge clk); mon_on = 1;
    for (int s = 0; s < NB; s++) step_bit(up ? s : NB - 1 - s);
    repeat (3) @(negedge clk);
    mon_on = 0;
    check(a_rise == k, {req, " A rises"}, a_rise, k);
    check(b_rise == k, {req, " B rises"}, b_rise, k);
    if (up) check(b_first - a_first == st, "R4 B lag", b_first - a_first, st);
    else    check(a_first - b_first == st, "R5 B lead", a_first - b_first, st);
    check(twins == 0, "R6 twin toggles", twins, 0);
  endtask

  initial begin
    #(100000 * 5);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(a_out == 0 && b_out == 0 && ref_out == 0, "R1 reset outputs", {a_out, b_out, ref_out}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: default factor is 1 without any load; R9: fsel changed while load_en low
    fsel = 2'd3;
    sweep(2'd0, 1'b1, "R1");
    // R2/R4 each factor, ascending
    for (int c = 0; c < 4; c++) begin
      load_factor(c[1:0]);
      sweep(c[1:0], 1'b1, "R4");
    end
    // R5 descending
    for (int c = 0; c < 4; c++) begin
      load_factor(c[1:0]);
      sweep(c[1:0], 1'b0, "R5");
    end
    // R9: fsel wiggled without a strobe keeps factor 4
    load_factor(2'd1);
    fsel = 2'd3;
    sweep(2'd1, 1'b1, "R9");
    // R3: all-zero vector gives both tracks low
    load_factor(2'd3);
    @(negedge clk); cmp_in = '0;
    repeat (3) @(negedge clk);
    check(a_out == 0 && b_out == 0, "R3 zero vector", {a_out, b_out}, 0);
    // R1: reset mid-run clears outputs
    @(negedge clk); cmp_in[0] = 1'b1; ref_cmp = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(a_out == 0 && b_out == 0 && ref_out == 0, "R1 async reset", {a_out, b_out, ref_out}, 0);
    @(negedge clk); rst_n = 1'b1; cmp_in = '0; ref_cmp = 1'b0;
    repeat (3) @(negedge clk);
    check(model_bad == 0, "R8 per-cycle model mismatches", model_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule